// File: doc/BRIEF.md
# Interleaved Block Transfer Sequencer

This block drives a long copy between local memory and a shared backplane bus. The backplane allows at most 256 bytes per burst, and a burst may not run across a 256-byte address page. Software writes a total byte count, a per-burst beat limit, an interleave gap and the two start addresses, then sets the start bit. From there the sequencer runs without software help. It requests the bus and, once granted, acts as local bus master, moving one byte per beat. When a burst has to end it drops the request and waits out the gap, then asks for the bus again. Both addresses stay in internal counters through the gap, so each burst resumes where the previous one stopped.

A burst ends for one of three reasons: the programmed beat limit is reached, the next backplane address would enter a new page, or the total count runs out. While the sequencer waits in the gap, the local bus is flagged as free so that an incoming backplane slave access can be served. A bus error on any beat aborts the copy and sets a sticky error flag. The single-cycle completion interrupt is raised in every case.

States: `S_IDLE` (waiting for start), `S_REQ` (requesting the bus), `S_BEAT` (strobes out, waiting for the acknowledge), `S_GAP` (bus released, timer running), `S_DONE` (interrupt cycle). Transitions: START (`S_IDLE`→`S_REQ`), EMPTY (`S_IDLE`→`S_DONE` on zero length), GRANT (`S_REQ`→`S_BEAT`), NEXT (`S_BEAT`→`S_BEAT`), BREAK (`S_BEAT`→`S_GAP`), LAST (`S_BEAT`→`S_DONE`), ABORT (`S_BEAT`→`S_DONE` on error), RESUME (`S_GAP`→`S_REQ`), RETIRE (`S_DONE`→`S_IDLE`).

Top module: `ibt_seq`

## Requirements
- R1: After reset, `busy`, `bus_req`, `bus_stb`, `lcl_rd`, `lcl_wr`, `err` and `done_irq` are low and `lcl_free` is high.
- R2: A write with `wr_en` high goes to the register chosen by `wr_sel`. Code 0 is the total length in bytes. Code 1 is the burst beat limit, whose low 8 bits are used and where 0 means 256. Code 2 is the gap period. Code 3 is the local start address and code 4 the backplane start address. Code 5 is control: bit 0 starts the transfer and bit 1 sets the direction. Codes 6 and 7 have no effect and never start a transfer.
- R3: `bus_req` is high in the cycle after the start write. Each beat moves one byte, and `bus_stb` and `bus_addr` stay unchanged until `xfer_ack` is sampled high.
- R4: No burst holds more beats than the programmed limit.
- R5: A burst always ends after the beat whose backplane address has low byte 0xFF, so no burst crosses a 256-byte page.
- R6: Between two bursts `bus_req` stays low for exactly gap+1 cycles.
- R7: Each beat's local and backplane address is one more than the previous beat's, including across gaps, with the carry going into the upper byte.
- R8: With direction 1 every beat pulses `lcl_rd`; with direction 0 every beat pulses `lcl_wr`; never both at once.
- R9: `done_irq` is high for exactly one cycle, the cycle after the last beat's acknowledge, and `busy` is low in that cycle.
- R10: `xfer_err` sampled during a beat aborts the transfer. No further strobe is issued, `err` is set and the interrupt still fires. `err` is cleared by the next start.
- R11: A start with total length 0 raises `done_irq` without ever asserting `bus_req`.
- R12: Register writes while a transfer is active are ignored; the running transfer keeps its length, beat limit and addresses.
- R13: `lcl_free` is high in idle and during the gap, and low while the bus is requested or a beat is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select code |
| wr_data | input | W | Register write data |
| bus_req | output | 1 | Backplane bus request |
| bus_gnt | input | 1 | Backplane bus grant |
| bus_stb | output | 1 | Backplane beat strobe |
| bus_addr | output | W | Backplane byte address of current beat |
| lcl_rd | output | 1 | Local read strobe (direction 1) |
| lcl_wr | output | 1 | Local write strobe (direction 0) |
| lcl_addr | output | W | Local byte address of current beat |
| xfer_ack | input | 1 | Beat acknowledge |
| xfer_err | input | 1 | Beat error response |
| lcl_free | output | 1 | Local bus free for slave service |
| busy | output | 1 | Transfer in progress |
| err | output | 1 | Sticky abort flag |
| done_irq | output | 1 | One-cycle completion interrupt |

## Verification
A wrong beat counter or a missed page wrap shows up at the ports on the very next beat. The backplane address would step into a new page inside one strobe run, or the strobe would fall too early, so the burst count and the per-beat address log differ from the model at once. A gap timer that is off by one changes the measured low time of `bus_req` in the first gap. A stale length counter or a lost address shows only at the end, as a wrong final address or a wrong beat total when `done_irq` fires. The error path is checked by a stuck strobe after the faulted beat, or by a missing interrupt.

// File: rtl/ibt_pkg.sv
package ibt_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_REQ,
        S_BEAT,
        S_GAP,
        S_DONE
    } ibt_state_t;

    localparam logic [2:0] SEL_LEN   = 3'd0;
    localparam logic [2:0] SEL_BURST = 3'd1;
    localparam logic [2:0] SEL_GAP   = 3'd2;
    localparam logic [2:0] SEL_LADDR = 3'd3;
    localparam logic [2:0] SEL_BADDR = 3'd4;
    localparam logic [2:0] SEL_CTRL  = 3'd5;

endpackage

// File: rtl/ibt_cfg.sv
module ibt_cfg
    import ibt_pkg::*;
#(
    parameter int W   = 16,
    parameter int PGW = 8,
    parameter int BCW = PGW + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [2:0]     wr_sel,
    input  logic [W-1:0]   wr_data,
    input  logic           idle,
    output logic [W-1:0]   len_o,
    output logic [BCW-1:0] lim_o,
    output logic [W-1:0]   gap_o,
    output logic           dir_o,
    output logic           go_o,
    output logic           ld_lcl_o,
    output logic           ld_bus_o
);

    logic           acc;
    logic [W-1:0]   len_q;
    logic [PGW-1:0] bst_q;
    logic [W-1:0]   gap_q;
    logic           dir_q;

    // writes only land while idle (R12)
    assign acc = wr_en && idle;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= '0;
            bst_q <= '0;
            gap_q <= '0;
            dir_q <= 1'b0;
        end else if (acc) begin
            case (wr_sel)
                SEL_LEN:   len_q <= wr_data;
                SEL_BURST: bst_q <= wr_data[PGW-1:0];
                SEL_GAP:   gap_q <= wr_data;
                SEL_CTRL:  dir_q <= wr_data[1];
                default: ;
            endcase
        end
    end

    assign len_o    = len_q;
    assign gap_o    = gap_q;
    assign dir_o    = dir_q;
    assign lim_o    = (bst_q == '0) ? (BCW'(1) << PGW) : BCW'(bst_q);
    assign go_o     = acc && (wr_sel == SEL_CTRL) && wr_data[0];
    assign ld_lcl_o = acc && (wr_sel == SEL_LADDR);
    assign ld_bus_o = acc && (wr_sel == SEL_BADDR);

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> ($stable(len_q) && $stable(bst_q) && $stable(gap_q))); // R12

endmodule

// File: rtl/ibt_addr_ctr.sv
module ibt_addr_ctr #(
    parameter int W   = 16,
    parameter int PGW = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         inc,
    output logic [W-1:0] addr_o
);

    localparam int UPW = W - PGW;

    logic [PGW-1:0] low_q;
    logic [UPW-1:0] page_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_q  <= '0;
            page_q <= '0;
        end else if (ld) begin
            {page_q, low_q} <= ld_val;
        end else if (inc) begin
            low_q <= low_q + PGW'(1);
            if (&low_q) page_q <= page_q + UPW'(1);
        end
    end

    assign addr_o = {page_q, low_q};

endmodule

// File: rtl/ibt_gap_timer.sv
module ibt_gap_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] period,
    input  logic         run,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= period;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign expired = (cnt_q == '0);

    AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= period)); // R6

endmodule

// File: rtl/ibt_seq.sv
module ibt_seq
    import ibt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [2:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    output logic         bus_req,
    input  logic         bus_gnt,
    output logic         bus_stb,
    output logic [W-1:0] bus_addr,
    output logic         lcl_rd,
    output logic         lcl_wr,
    output logic [W-1:0] lcl_addr,
    input  logic         xfer_ack,
    input  logic         xfer_err,
    output logic         lcl_free,
    output logic         busy,
    output logic         err,
    output logic         done_irq
);

    localparam int PGW = 8;
    localparam int BCW = PGW + 1;

    ibt_state_t     state_q, state_d;
    logic [W-1:0]   len_w, gap_w, rem_q;
    logic [BCW-1:0] lim_w, beats_q;
    logic           dir_w, go_w, ld_lcl_w, ld_bus_w;
    logic           beat_done, last_beat, brk, bus_wrap, gap_expired, err_q;

    ibt_cfg #(.W(W), .PGW(PGW), .BCW(BCW)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .idle     (state_q == S_IDLE),
        .len_o    (len_w),
        .lim_o    (lim_w),
        .gap_o    (gap_w),
        .dir_o    (dir_w),
        .go_o     (go_w),
        .ld_lcl_o (ld_lcl_w),
        .ld_bus_o (ld_bus_w)
    );

    ibt_addr_ctr #(.W(W), .PGW(PGW)) u_lcl_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (ld_lcl_w),
        .ld_val (wr_data),
        .inc    (beat_done),
        .addr_o (lcl_addr)
    );

    ibt_addr_ctr #(.W(W), .PGW(PGW)) u_bus_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (ld_bus_w),
        .ld_val (wr_data),
        .inc    (beat_done),
        .addr_o (bus_addr)
    );

    ibt_gap_timer #(.W(W)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    ((state_q == S_BEAT) && (state_d == S_GAP)),
        .period  (gap_w),
        .run     (state_q == S_GAP),
        .expired (gap_expired)
    );

    assign beat_done = (state_q == S_BEAT) && xfer_ack && !xfer_err;
    assign last_beat = (rem_q == W'(1));
    assign bus_wrap  = (bus_addr[PGW-1:0] == '1);
    assign brk       = (BCW'(beats_q + BCW'(1)) == lim_w) || bus_wrap;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (go_w) state_d = (len_w == '0) ? S_DONE : S_REQ; // START / EMPTY
            S_REQ:  if (bus_gnt) state_d = S_BEAT;                      // GRANT
            S_BEAT: begin
                if (xfer_err)       state_d = S_DONE;                   // ABORT
                else if (xfer_ack) begin
                    if (last_beat)  state_d = S_DONE;                   // LAST
                    else if (brk)   state_d = S_GAP;                    // BREAK
                    else            state_d = S_BEAT;                   // NEXT
                end
            end
            S_GAP:  if (gap_expired) state_d = S_REQ;                   // RESUME
            S_DONE: state_d = S_IDLE;                                   // RETIRE
            default: state_d = S_IDLE;
        endcase
    end

    // datapath counters and error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q   <= '0;
            beats_q <= '0;
            err_q   <= 1'b0;
        end else begin
            if (go_w) begin
                rem_q <= len_w;
                err_q <= 1'b0;
            end else if (beat_done) begin
                rem_q <= rem_q - W'(1);
            end
            if (state_q == S_REQ)  beats_q <= '0;
            else if (beat_done)    beats_q <= beats_q + BCW'(1);
            if ((state_q == S_BEAT) && xfer_err) err_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        bus_req  = 1'b0;
        bus_stb  = 1'b0;
        lcl_rd   = 1'b0;
        lcl_wr   = 1'b0;
        lcl_free = 1'b0;
        busy     = 1'b0;
        done_irq = 1'b0;
        unique case (state_q)
            S_IDLE: lcl_free = 1'b1;
            S_REQ: begin
                bus_req = 1'b1;
                busy    = 1'b1;
            end
            S_BEAT: begin
                bus_req = 1'b1;
                bus_stb = 1'b1;
                lcl_rd  = dir_w;
                lcl_wr  = !dir_w;
                busy    = 1'b1;
            end
            S_GAP: begin
                lcl_free = 1'b1;
                busy     = 1'b1;
            end
            S_DONE: done_irq = 1'b1;
            default: ;
        endcase
    end

    assign err = err_q;

    AST_STB_HAS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stb |-> bus_req); // R3
    AST_BURST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stb |-> (beats_q < lim_w)); // R4
    AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stb && $past(bus_stb)) |-> (bus_addr[W-1:PGW] == $past(bus_addr[W-1:PGW]))); // R5
    AST_GAP_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_GAP) && ($past(state_q) == S_GAP)) |-> ($stable(bus_addr) && $stable(lcl_addr))); // R7
    AST_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        !(lcl_rd && lcl_wr)); // R8
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq); // R9
    AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> (!bus_stb && !bus_req)); // R10

endmodule

// File: tb/ibt_seq_tb.sv
module ibt_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_sel = '0;
    logic [W-1:0] wr_data = '0;
    logic         bus_req, bus_stb, lcl_rd, lcl_wr, lcl_free, busy, err, done_irq;
    logic         bus_gnt = 1'b0;
    logic         xfer_ack = 1'b0;
    logic         xfer_err = 1'b0;
    logic [W-1:0] bus_addr, lcl_addr;

    ibt_seq #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_stb(bus_stb), .bus_addr(bus_addr),
        .lcl_rd(lcl_rd), .lcl_wr(lcl_wr), .lcl_addr(lcl_addr),
        .xfer_ack(xfer_ack), .xfer_err(xfer_err), .lcl_free(lcl_free),
        .busy(busy), .err(err), .done_irq(done_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int nchk = 0, nerr = 0;
    int nb, nbursts, ngaps, gmin, gmax, gap_run, nreq, nirq, nrd, nwr;
    int hold_bad, both_bad, free_bad;
    int err_at = -1;
    bit slow = 1'b0, tog = 1'b0;
    bit prev_stb = 1'b0, prev_ack = 1'b0;
    logic [W-1:0] prev_addr = '0;
    logic [W-1:0] ba [0:63];
    logic [W-1:0] la [0:63];

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // bus and local responder plus monitor, all at the falling edge
    always @(negedge clk) begin
        if (!rst_n) begin
            bus_gnt = 1'b0; xfer_ack = 1'b0; xfer_err = 1'b0;
        end else begin
            bus_gnt = bus_req;
            if (bus_req) nreq++;
            if (done_irq) nirq++;
            if (lcl_rd && lcl_wr) both_bad++;
            if (bus_stb && prev_stb && !prev_ack && bus_addr != prev_addr) hold_bad++;
            if (bus_stb && !prev_stb) nbursts++;
            if ((bus_req && lcl_free) || (busy && !bus_req && !lcl_free) ||
                (!busy && !done_irq && !lcl_free)) free_bad++;
            if (busy && !bus_req) gap_run++;
            else if (gap_run > 0) begin
                ngaps++;
                if (gap_run < gmin) gmin = gap_run;
                if (gap_run > gmax) gmax = gap_run;
                gap_run = 0;
            end
            xfer_ack = 1'b0;
            xfer_err = 1'b0;
            if (bus_stb) begin
                tog = !tog;
                if (!slow || tog) begin
                    if (nb == err_at) xfer_err = 1'b1;
                    else begin
                        xfer_ack = 1'b1;
                        if (nb < 64) begin ba[nb] = bus_addr; la[nb] = lcl_addr; end
                        if (lcl_rd) nrd++;
                        if (lcl_wr) nwr++;
                        nb++;
                    end
                end
            end
            prev_stb = bus_stb; prev_ack = xfer_ack; prev_addr = bus_addr;
        end
    end

    task automatic wr(input logic [2:0] sel, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clear_stats();
        @(posedge clk);
        nb = 0; nbursts = 0; ngaps = 0; gmin = 1000000; gmax = 0; gap_run = 0;
        nreq = 0; nirq = 0; nrd = 0; nwr = 0; hold_bad = 0; both_bad = 0; free_bad = 0;
    endtask

    task automatic run_xfer(input logic [W-1:0] la0, input logic [W-1:0] ba0,
                            input logic [W-1:0] len, input logic [W-1:0] bst,
                            input logic [W-1:0] gap, input bit dir, input bit mid);
        wr(3'd3, la0); wr(3'd4, ba0); wr(3'd0, len); wr(3'd1, bst); wr(3'd2, gap);
        clear_stats();
        wr(3'd5, {14'd0, dir, 1'b1});
        if (mid) begin
            wr(3'd0, 16'd40); wr(3'd1, 16'd1); wr(3'd4, 16'd0); wr(3'd5, 16'd1);
        end
        wait (nirq > 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 bus_req", bus_req, 0);
        chk("R1 strobes", bus_stb | lcl_rd | lcl_wr, 0);
        chk("R1 irq/err", done_irq | err, 0);
        chk("R1 lcl_free", lcl_free, 1);
    endtask

    task automatic t_single();
        run_xfer(16'h3000, 16'h0010, 16'd4, 16'd16, 16'd3, 1'b1, 1'b0);
        chk("R3 beats", nb, 4);
        chk("R3 bursts", nbursts, 1);
        chk("R7 last bus addr", int'(ba[3]), 16'h0013);
        chk("R7 last lcl addr", int'(la[3]), 16'h3003);
        chk("R8 reads", nrd, 4);
        chk("R8 writes", nwr, 0);
        chk("R9 irq count", nirq, 1);
        chk("R9 busy after", busy, 0);
    endtask

    task automatic t_limit_gap();
        slow = 1'b1;
        run_xfer(16'h0400, 16'h0020, 16'd10, 16'd4, 16'd5, 1'b0, 1'b0);
        slow = 1'b0;
        chk("R4 bursts", nbursts, 3);
        chk("R4 beats", nb, 10);
        chk("R6 gaps", ngaps, 2);
        chk("R6 gap min", gmin, 6);
        chk("R6 gap max", gmax, 6);
        chk("R7 resume bus addr", int'(ba[4]), 16'h0024);
        chk("R7 final bus addr", int'(ba[9]), 16'h0029);
        chk("R7 resume lcl addr", int'(la[8]), 16'h0408);
        chk("R3 held until ack", hold_bad, 0);
        chk("R8 writes", nwr, 10);
        chk("R8 never both", both_bad, 0);
        chk("R13 lcl_free", free_bad, 0);
    endtask

    task automatic t_page();
        run_xfer(16'h00FE, 16'h01FC, 16'd8, 16'd0, 16'd2, 1'b1, 1'b0);
        chk("R5 bursts", nbursts, 2);
        chk("R5 last of page", int'(ba[3]), 16'h01FF);
        chk("R5 first of next page", int'(ba[4]), 16'h0200);
        chk("R6 gap", gmax, 3);
        chk("R7 local carry", int'(la[2]), 16'h0100);
    endtask

    task automatic t_error();
        err_at = 2;
        run_xfer(16'h0000, 16'h0040, 16'd6, 16'd8, 16'd1, 1'b1, 1'b0);
        err_at = -1;
        chk("R10 beats before abort", nb, 2);
        chk("R10 err flag", err, 1);
        chk("R10 irq", nirq, 1);
        chk("R10 bus released", bus_req | bus_stb, 0);
        run_xfer(16'h0000, 16'h0050, 16'd2, 16'd8, 16'd1, 1'b1, 1'b0);
        chk("R10 err cleared", err, 0);
        chk("R10 next run beats", nb, 2);
    endtask

    task automatic t_zero();
        run_xfer(16'h0000, 16'h0000, 16'd0, 16'd8, 16'd1, 1'b1, 1'b0);
        chk("R11 irq", nirq, 1);
        chk("R11 no request", nreq, 0);
    endtask

    task automatic t_busy_writes();
        run_xfer(16'h0800, 16'h0100, 16'd6, 16'd2, 16'd4, 1'b1, 1'b1);
        chk("R12 beats", nb, 6);
        chk("R12 bursts", nbursts, 3);
        chk("R12 last bus addr", int'(ba[5]), 16'h0105);
        chk("R12 irq", nirq, 1);
    endtask

    task automatic t_bad_sel();
        clear_stats();
        wr(3'd7, 16'h0003);
        wr(3'd6, 16'h0003);
        repeat (3) @(negedge clk);
        chk("R2 no start busy", busy, 0);
        chk("R2 no start req", nreq, 0);
        run_xfer(16'h0000, 16'h0060, 16'd3, 16'd8, 16'd1, 1'b1, 1'b0);
        chk("R2 length kept", nb, 3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_limit_gap();
        t_page();
        t_error();
        t_zero();
        t_busy_writes();
        t_bad_sel();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule